// File: doc/BRIEF.md
# Serial-to-Parallel Word Latch

This block is an SPI slave that turns 16-bit serial frames into a held parallel word. While the active-low select input is low, each rising edge of the serial clock moves one MOSI bit into a shift register, most significant bit first. When select returns high, the assembled word is copied into an output register. That register drives eight data lines and a group of control lines for a parallel peripheral. The outputs keep that value until the next frame ends.

The three serial inputs are sampled with the block's own clock through a synchronizer, and their edges are found in that clock domain. A frame can therefore be aborted, cut short or overrun without the parallel outputs moving mid-frame. Each frame starts from a cleared shift register. If more than 16 clocks arrive, the last 16 bits shifted in are the ones kept. An optional MISO output returns the bit that falls out of the top of the shift register. This lets devices be chained or a frame be echoed back.

Top module: `spi_par_latch`

## Requirements
- R1: After reset, `par_data` and `par_ctrl` are all zeros and `spi_miso` is 0.
- R2: A frame of 16 rising `spi_sck` edges with `spi_cs_n` low latches the word whose bit 15 is the first MOSI bit sampled and whose bit 0 is the last.
- R3: `par_data` carries bits 7..0 of the latched word and `par_ctrl` carries bits 15..8.
- R4: During a frame, while `spi_cs_n` is low, `par_data` and `par_ctrl` keep the previous frame's value. They change only after `spi_cs_n` goes from low to high.
- R5: `spi_sck` and `spi_mosi` activity while `spi_cs_n` is high changes neither the outputs nor the next frame's result.
- R6: The shift register is cleared when `spi_cs_n` falls. A frame with fewer than 16 clocks latches its bits in the low positions, with zeros above them. A frame with no clocks latches zero.
- R7: A frame with more than 16 clocks latches the last 16 bits shifted in.
- R8: Between frames the parallel outputs hold their value for as long as `spi_cs_n` stays high.
- R9: While selected, `spi_miso` shows bit 15 of the shift register. It is 0 for the first 16 clocks of a frame and then returns the frame's earlier bits in the order they arrived. It is 0 while `spi_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to sample the serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| spi_sck | input | 1 | Serial clock from the master; data is taken on its rising edge |
| spi_cs_n | input | 1 | Active-low slave select; its rising edge latches the word |
| spi_mosi | input | 1 | Serial data from the master, MSB first |
| spi_miso | output | 1 | Top bit of the shift register while selected, else 0 |
| par_data | output | 8 | Low byte of the latched word |
| par_ctrl | output | 8 | High byte of the latched word (control lines) |

## Verification
Full 16-clock frames use several patterns: strobe-style command words, an alternating pattern, a single set bit and a dense pattern. These confirm the MSB-first order and the split into data and control bytes. A frame cut short at 8 clocks and one with 4 clocks following deselected toggling show whether the register is cleared at select. Together with a zero-clock frame, they separate clearing from accidental carry-over. A 20-clock and a 32-clock frame show that the last 16 bits win. The 32-clock frame also checks that MISO returns the first half of that frame. Outputs are compared mid-frame, before select rises, and after long idle gaps, so that early updates and lost holds are told apart.

// File: rtl/spi_par_pkg.sv
package spi_par_pkg;

  localparam int unsigned WORD_W_DEF = 16;
  localparam int unsigned DATA_W_DEF = 8;
  localparam int unsigned SYNC_STAGES_DEF = 2;

  // one synchronized input with its detected edges
  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } sig_edge_t;

endpackage

// File: rtl/spi_par_rst_sync.sv
module spi_par_rst_sync #(
  parameter int unsigned STAGES = spi_par_pkg::SYNC_STAGES_DEF
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_out = chain_q[STAGES-1];

endmodule

// File: rtl/spi_par_in_sync.sv
module spi_par_in_sync
  import spi_par_pkg::*;
#(
  parameter int unsigned W       = 3,
  parameter int unsigned STAGES  = SYNC_STAGES_DEF,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    din,
  output sig_edge_t [W-1:0] sig
);

  logic [STAGES-1:0][W-1:0] stg_q;
  logic [W-1:0]             prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < int'(STAGES); s++) begin
        stg_q[s] <= RST_VAL;
      end
      prev_q <= RST_VAL;
    end else begin
      stg_q[0] <= din;
      for (int s = 1; s < int'(STAGES); s++) begin
        stg_q[s] <= stg_q[s-1];
      end
      prev_q <= stg_q[STAGES-1];
    end
  end

  for (genvar b = 0; b < int'(W); b++) begin : g_edge
    assign sig[b].level = stg_q[STAGES-1][b];
    assign sig[b].rise  = stg_q[STAGES-1][b] & ~prev_q[b];
    assign sig[b].fall  = ~stg_q[STAGES-1][b] & prev_q[b];
  end

endmodule

// File: rtl/spi_par_shifter.sv
module spi_par_shifter
  import spi_par_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sig_edge_t         sel_n,
  input  sig_edge_t         sck,
  input  logic              mosi,
  output logic [WORD_W-1:0] word,
  output logic              top_bit
);

  logic [WORD_W-1:0] sh_q;
  logic [WORD_W-1:0] sh_d;
  logic              clr_en;
  logic              shift_en;

  assign clr_en   = sel_n.fall;
  assign shift_en = sck.rise & ~sel_n.level & ~sel_n.fall;

  always_comb begin
    sh_d = sh_q;
    if (clr_en) begin
      sh_d = '0;
    end else if (shift_en) begin
      sh_d = {sh_q[WORD_W-2:0], mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (clr_en || shift_en) begin
      sh_q <= sh_d;
    end
  end

  assign word    = sh_q;
  assign top_bit = sh_q[WORD_W-1];

  AST_CLEAR_AT_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n.fall |=> (sh_q == '0)); // R6

  AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n.level |=> $stable(sh_q)); // R5

  AST_SHIFT_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (sck.rise && !sel_n.level && !sel_n.fall) |=>
      (sh_q == {$past(sh_q[WORD_W-2:0]), $past(mosi)})); // R2

endmodule

// File: rtl/spi_par_holder.sv
module spi_par_holder #(
  parameter int unsigned WORD_W = spi_par_pkg::WORD_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latch_en,
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] word_q
);

  logic [WORD_W-1:0] hold_q;
  logic [WORD_W-1:0] hold_d;

  always_comb begin
    hold_d = hold_q;
    if (latch_en) begin
      hold_d = word_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (latch_en) begin
      hold_q <= hold_d;
    end
  end

  assign word_q = hold_q;

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_en |=> $stable(hold_q)); // R8

endmodule

// File: rtl/spi_par_latch.sv
module spi_par_latch
  import spi_par_pkg::*;
#(
  parameter int unsigned WORD_W      = WORD_W_DEF,
  parameter int unsigned DATA_W      = DATA_W_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF,
  parameter bit          MISO_EN     = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     spi_sck,
  input  logic                     spi_cs_n,
  input  logic                     spi_mosi,
  output logic                     spi_miso,
  output logic [DATA_W-1:0]        par_data,
  output logic [WORD_W-DATA_W-1:0] par_ctrl
);

  localparam int unsigned CTRL_W = WORD_W - DATA_W;
  localparam int unsigned IDX_SCK  = 0;
  localparam int unsigned IDX_SEL  = 1;
  localparam int unsigned IDX_MOSI = 2;
  localparam logic [2:0]  IN_RST = 3'b010;

  logic            rst_sync_n;
  sig_edge_t [2:0] in_sig;
  logic [WORD_W-1:0] sh_word;
  logic [WORD_W-1:0] held_word;
  logic            sh_top;
  logic            latch_en;

  spi_par_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  spi_par_in_sync #(
    .W       (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (IN_RST)
  ) u_in_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .din   ({spi_mosi, spi_cs_n, spi_sck}),
    .sig   (in_sig)
  );

  spi_par_shifter #(.WORD_W(WORD_W)) u_shifter (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .sel_n   (in_sig[IDX_SEL]),
    .sck     (in_sig[IDX_SCK]),
    .mosi    (in_sig[IDX_MOSI].level),
    .word    (sh_word),
    .top_bit (sh_top)
  );

  assign latch_en = in_sig[IDX_SEL].rise;

  spi_par_holder #(.WORD_W(WORD_W)) u_holder (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .latch_en (latch_en),
    .word_in  (sh_word),
    .word_q   (held_word)
  );

  assign par_data = held_word[DATA_W-1:0];
  assign par_ctrl = held_word[WORD_W-1:DATA_W];

  if (MISO_EN) begin : g_miso
    assign spi_miso = sh_top & ~in_sig[IDX_SEL].level;
  end else begin : g_no_miso
    assign spi_miso = 1'b0;
  end

  initial begin
    assert (CTRL_W > 0 && SYNC_STAGES >= 2)
      else $error("spi_par_latch: bad parameters");
  end

  AST_NO_MIDFRAME_UPDATE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_sig[IDX_SEL].level |=> $stable({par_ctrl, par_data})); // R4

  AST_MISO_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_sig[IDX_SEL].level |-> (spi_miso == 1'b0)); // R9

endmodule

// File: tb/spi_par_latch_bench.sv
`timescale 1ns/1ps
module spi_par_latch_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       spi_sck;
  logic       spi_cs_n;
  logic       spi_mosi;
  logic       spi_miso;
  logic [7:0] par_data;
  logic [7:0] par_ctrl;

  int n_checks = 0;
  int n_fail   = 0;
  int pending  = 0;
  logic [15:0] sb_q[$];
  logic [15:0] last_word = 16'h0000;

  always #2.5 clk = ~clk;

  spi_par_latch u_spi_par_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_sck  (spi_sck),
    .spi_cs_n (spi_cs_n),
    .spi_mosi (spi_mosi),
    .spi_miso (spi_miso),
    .par_data (par_data),
    .par_ctrl (par_ctrl)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Driver: sends n bits MSB first, models the expected word and MISO stream
  task automatic run_frame(input logic [63:0] bits, input int n);
    logic [15:0] m;
    logic        miso_bad;
    m = 16'h0000;
    miso_bad = 1'b0;
    ticks(1);
    spi_cs_n = 1'b0;
    ticks(6);
    for (int i = n - 1; i >= 0; i--) begin
      spi_mosi = bits[i];
      ticks(3);
      if (spi_miso !== m[15]) miso_bad = 1'b1;
      spi_sck = 1'b1;
      m = {m[14:0], bits[i]};
      ticks(6);
      spi_sck = 1'b0;
      ticks(3);
    end
    ticks(6);
    if (n > 0) chk("R9 miso stream", {31'd0, miso_bad}, 32'd0);
    chk("R4 outputs before select rise", {16'd0, par_ctrl, par_data}, {16'd0, last_word});
    spi_cs_n = 1'b1;
    ticks(8);
    sb_q.push_back(m);
    pending++;
    last_word = m;
    wait (pending == 0);
    ticks(2);
  endtask

  // Monitor: pops expected words and compares the parallel outputs
  initial begin
    logic [15:0] e;
    forever begin
      wait (pending != 0);
      @(negedge clk);
      e = sb_q.pop_front();
      chk("R2 latched word", {16'd0, par_ctrl, par_data}, {16'd0, e});
      chk("R3 data byte", {24'd0, par_data}, {24'd0, e[7:0]});
      chk("R3 ctrl byte", {24'd0, par_ctrl}, {24'd0, e[15:8]});
      pending--;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic bad;
    rst_n = 1'b0;
    spi_sck = 1'b0;
    spi_cs_n = 1'b1;
    spi_mosi = 1'b0;
    ticks(5);
    rst_n = 1'b1;
    ticks(6);
    chk("R1 reset outputs", {16'd0, par_ctrl, par_data}, 32'd0);
    chk("R1 reset miso", {31'd0, spi_miso}, 32'd0);

    // R2 R3: full frames with distinct patterns
    run_frame(64'h05F0, 16);
    run_frame(64'h04F0, 16);
    run_frame(64'hFF0A, 16);
    run_frame(64'h0001, 16);
    run_frame(64'hA5C3, 16);

    // R8: hold over a long idle gap
    ticks(60);
    chk("R8 hold after idle", {16'd0, par_ctrl, par_data}, {16'd0, last_word});

    // R6: short frame, upper bits zero
    run_frame(64'h00C3, 8);

    // R5: deselected toggling has no effect
    bad = 1'b0;
    for (int k = 0; k < 20; k++) begin
      spi_mosi = 1'b1;
      ticks(3);
      spi_sck = ~spi_sck;
      ticks(3);
      if (spi_miso !== 1'b0) bad = 1'b1;
    end
    spi_sck = 1'b0;
    ticks(10);
    chk("R5 outputs after idle clocks", {16'd0, par_ctrl, par_data}, {16'd0, last_word});
    chk("R9 miso idle", {31'd0, bad}, 32'd0);
    run_frame(64'h000A, 4);

    // R6: empty frame latches zero
    run_frame(64'h0, 0);

    // R7: overrun frames keep the last 16 bits
    run_frame(64'hF1357, 20);
    run_frame(64'h1234BEEF, 32);

    ticks(20);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule